// File: doc/BRIEF.md
# Crate Service-Request Source and Mask Controller

This block holds the service-request (LAM) bookkeeping of a crate slave module. A source register collects pending conditions, a mask register selects which of them may raise the request line, and a software enable gates the whole line. The dataway side presents a decoded function number, a subaddress, a strobe and 16 bits of write data. The block answers with read data and a command-accepted (X) response. Hardware event inputs set source bits on their rising edge. Bit 0 is the transmit-FIFO-full flag and bit 1 is the receive-FIFO-full flag.

The LAM line is registered. It is recomputed only when an accepted dataway command changes the source or mask register, and on each pulse of a periodic update tick. At any other time it holds its value. A change of the software enable therefore shows on the line only at the next such update. A separate output mirrors the software enable so that it can drive a front-panel indicator.

Top module: `lam_ctl`

## Requirements
- R1: After reset the source and mask registers read 0, the software enable is off, and lam_o is 0.
- R2: A strobe with func_i=7 returns the source register for sub_i=0 and the mask register for sub_i=1 on rdata_o, combinationally. rdata_o is 0 whenever no read is accepted.
- R3: A strobe with func_i=22 loads wdata_i into the source register for sub_i=0 and into the mask register for sub_i=1.
- R4: A strobe with func_i=10 clears source bit 0, 1 or 2 for sub_i=0, 1 or 2. With sub_i=15 it clears every source bit.
- R5: A strobe with func_i=26, sub_i=0 turns the software enable on. A strobe with func_i=24, sub_i=0 turns it off. lam_en_o shows the enable from the next cycle.
- R6: At an update, lam_o takes the value enable AND (OR over all bits of source AND mask), using the register values that result from that cycle.
- R7: An update happens on a tick_i pulse, or on an accepted func_i=10 or func_i=22 strobe. In every other cycle lam_o keeps its value, and this includes cycles with enable changes or source events.
- R8: A rising edge on evt_i[i] sets source bit i (bit 0 is transmit FIFO full, bit 1 is receive FIFO full). An input that stays high does not set the bit again after the bit is cleared.
- R9: When an event edge and a dataway clear or write of the same source bit fall in the same cycle, the bit ends up set.
- R10: x_o is 1 only during a strobe with one of the combinations named in R2 to R5. Any other strobe leaves every register unchanged and returns rdata_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Dataway command strobe |
| func_i | input | 5 | Function number, binary |
| sub_i | input | 4 | Subaddress, binary |
| wdata_i | input | DW | Write data |
| evt_i | input | EVT_W | Hardware event inputs, rising-edge active |
| tick_i | input | 1 | Periodic update pulse |
| rdata_o | output | DW | Read data |
| x_o | output | 1 | Command accepted |
| lam_o | output | 1 | Service-request line |
| lam_en_o | output | 1 | Software enable status |

## Verification
The main function is exercised in four ways. First, masked and unmasked source patterns are written, which separates the AND of source with mask from a plain OR of the source. Second, single-bit clears are compared with the clear-all subaddress. Third, enable toggles are placed without a following update, so that a line that reacts too early can be caught. Fourth, unlisted function and subaddress pairs are applied, which shows that a loose decoder corrupts a register or raises X. Event edges are driven while the input is held high and in the same cycle as a clear, which separates edge detection from level sensing and shows which side wins.

// File: rtl/lam_ctl.sv
module lam_ctl #(
  parameter int DW    = 16,
  parameter int EVT_W = 2,
  parameter int NCLR  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic [4:0]       func_i,
  input  logic [3:0]       sub_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             tick_i,
  output logic [DW-1:0]    rdata_o,
  output logic             x_o,
  output logic             lam_o,
  output logic             lam_en_o
);
  localparam logic [4:0] F_READ = 5'd7;
  localparam logic [4:0] F_CLR  = 5'd10;
  localparam logic [4:0] F_LOAD = 5'd22;
  localparam logic [4:0] F_DIS  = 5'd24;
  localparam logic [4:0] F_ENA  = 5'd26;
  localparam logic [3:0] A_ALL  = 4'd15;

  logic [DW-1:0]    src_q, mask_q, src_dw, src_n, mask_n, evt_set;
  logic [EVT_W-1:0] evt_q, rise;
  logic             en_q, en_n;

  wire sel_rd  = (func_i == F_READ) && (sub_i < 4'd2);
  wire sel_one = (func_i == F_CLR)  && (32'(sub_i) < NCLR);
  wire sel_all = (func_i == F_CLR)  && (sub_i == A_ALL);
  wire sel_ld  = (func_i == F_LOAD) && (sub_i < 4'd2);
  wire sel_dis = (func_i == F_DIS)  && (sub_i == 4'd0);
  wire sel_ena = (func_i == F_ENA)  && (sub_i == 4'd0);

  assign x_o = strobe_i & (sel_rd | sel_one | sel_all | sel_ld | sel_dis | sel_ena);
  assign rdata_o = (strobe_i && sel_rd) ? (sub_i[0] ? mask_q : src_q) : '0;
  assign lam_en_o = en_q;

  assign rise = evt_i & ~evt_q;

  always_comb begin
    evt_set = '0;
    evt_set[EVT_W-1:0] = rise;
  end

  always_comb begin
    src_dw = src_q;
    mask_n = mask_q;
    en_n   = en_q;
    if (strobe_i) begin
      if (sel_one)                src_dw = src_q & ~(DW'(1) << sub_i);
      if (sel_all)                src_dw = '0;
      if (sel_ld && !sub_i[0])    src_dw = wdata_i;
      if (sel_ld && sub_i[0])     mask_n = wdata_i;
      if (sel_dis)                en_n   = 1'b0;
      if (sel_ena)                en_n   = 1'b1;
    end
    src_n = src_dw | evt_set;
  end

  wire update = tick_i | (strobe_i & (sel_one | sel_all | sel_ld));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
      evt_q  <= '0;
      lam_o  <= 1'b0;
    end else begin
      src_q  <= src_n;
      mask_q <= mask_n;
      en_q   <= en_n;
      evt_q  <= evt_i;
      if (update) lam_o <= en_n & (|(src_n & mask_n));
    end
  end
endmodule

// File: rtl/lam_ctl_chk.sv
module lam_ctl_chk #(
  parameter int DW    = 16,
  parameter int EVT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe_i,
  input logic [4:0]       func_i,
  input logic [EVT_W-1:0] evt_i,
  input logic             tick_i,
  input logic             x_o,
  input logic             lam_o,
  input logic             lam_en_o,
  input logic [DW-1:0]    src_q,
  input logic [DW-1:0]    mask_q
);
  // R7
  lam_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !(x_o && (func_i == 5'd10 || func_i == 5'd22))) |=> $stable(lam_o));
  // R6
  lam_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (lam_o == (lam_en_o && (|(src_q & mask_q)))));
  // R5
  en_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_o && func_i == 5'd26) |=> lam_en_o);
  // R5
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_o && func_i == 5'd24) |=> !lam_en_o);
  // R10
  x_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |-> !x_o);
  // R8
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_i[0]) |=> src_q[0]);
endmodule

bind lam_ctl lam_ctl_chk #(.DW(DW), .EVT_W(EVT_W)) chk_i (.*);

// File: tb/lam_ctl_tb.sv
module lam_ctl_tb_top;
  logic        clk = 0, rst_n = 0, strobe = 0, tick = 0;
  logic [4:0]  func = 0;
  logic [3:0]  sub = 0;
  logic [15:0] wdata = 0, rdata;
  logic [1:0]  evt = 0;
  logic        x, lam, lam_en;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  lam_ctl dut_i (.clk(clk), .rst_n(rst_n), .strobe_i(strobe), .func_i(func), .sub_i(sub),
                 .wdata_i(wdata), .evt_i(evt), .tick_i(tick), .rdata_o(rdata), .x_o(x),
                 .lam_o(lam), .lam_en_o(lam_en));

  // {strobe, func, sub, wdata, tick, exp_x, exp_lam, exp_rdata}
  localparam int NV = 20;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 5'd26, 4'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000}, // R5
    {1'b1, 5'd22, 4'd1,  16'h0005, 1'b0, 1'b1, 1'b0, 16'h0000}, // R3
    {1'b1, 5'd22, 4'd0,  16'h0004, 1'b0, 1'b1, 1'b1, 16'h0000}, // R3 R6
    {1'b1, 5'd7,  4'd0,  16'h0000, 1'b0, 1'b1, 1'b1, 16'h0004}, // R2
    {1'b1, 5'd7,  4'd1,  16'h0000, 1'b0, 1'b1, 1'b1, 16'h0005}, // R2
    {1'b1, 5'd10, 4'd2,  16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000}, // R4
    {1'b1, 5'd22, 4'd0,  16'h00F1, 1'b0, 1'b1, 1'b1, 16'h0000}, // R6
    {1'b1, 5'd24, 4'd0,  16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000}, // R7
    {1'b0, 5'd0,  4'd0,  16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000}, // R7 tick
    {1'b1, 5'd26, 4'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000}, // R7
    {1'b0, 5'd0,  4'd0,  16'h0000, 1'b1, 1'b0, 1'b1, 16'h0000}, // R6 tick
    {1'b1, 5'd10, 4'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000}, // R4
    {1'b1, 5'd7,  4'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 16'h00F0}, // R4
    {1'b1, 5'd10, 4'd15, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000}, // R4
    {1'b1, 5'd7,  4'd0,  16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000}, // R4
    {1'b1, 5'd3,  4'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R10
    {1'b1, 5'd10, 4'd3,  16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R10
    {1'b1, 5'd22, 4'd2,  16'hFFFF, 1'b0, 1'b0, 1'b0, 16'h0000}, // R10
    {1'b1, 5'd7,  4'd1,  16'h0000, 1'b0, 1'b1, 1'b0, 16'h0005}, // R10
    {1'b1, 5'd24, 4'd1,  16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}  // R10
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [4:0] f, input logic [3:0] a,
                       input logic [15:0] w, input logic t);
    strobe = s; func = f; sub = a; wdata = w; tick = t;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic rd_src(input string req, input logic [15:0] exp);
    drive(1, 5'd7, 4'd0, 0, 0);
    #1 chk(req, rdata, exp);
    idle();
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 lam", {15'd0, lam}, 16'd0);
    chk("R1 en", {15'd0, lam_en}, 16'd0);
    rd_src("R1 source", 16'h0000);
    drive(1, 5'd7, 4'd1, 0, 0);
    #1 chk("R1 mask", rdata, 16'h0000);
    idle();

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      drive(v[44], v[43:39], v[38:35], v[34:19], v[18]);
      #1;
      chk($sformatf("R10 x vec%0d", i), {15'd0, x}, {15'd0, v[17]});
      chk($sformatf("R2 rdata vec%0d", i), rdata, v[15:0]);
      @(posedge clk); #1;
      chk($sformatf("R6 lam vec%0d", i), {15'd0, lam}, {15'd0, v[16]});
      idle();
    end
    // R10 invalid disable left enable on
    chk("R10 en kept", {15'd0, lam_en}, 16'd1);

    // R8 event edge sets bit 0; R7 lam waits for update
    evt = 2'b01;
    @(posedge clk); #1;
    chk("R7 lam held after event", {15'd0, lam}, 16'd0);
    rd_src("R8 event sets bit0", 16'h0001);
    drive(0, 0, 0, 0, 1);
    @(posedge clk); #1;
    idle();
    chk("R6 lam after tick", {15'd0, lam}, 16'd1);
    // R8 held level does not re-set after clear
    drive(1, 5'd10, 4'd0, 0, 0);
    @(posedge clk); #1;
    idle();
    chk("R4 lam after clear", {15'd0, lam}, 16'd0);
    @(posedge clk); @(posedge clk); #1;
    rd_src("R8 held level no reset", 16'h0000);
    evt = 2'b00;
    @(posedge clk); #1;
    // R9 event beats same-cycle clear
    evt = 2'b10;
    drive(1, 5'd10, 4'd1, 0, 0);
    @(posedge clk); #1;
    idle();
    rd_src("R9 event wins over clear", 16'h0002);
    evt = 2'b11;
    drive(1, 5'd10, 4'd15, 0, 0);
    @(posedge clk); #1;
    idle();
    rd_src("R9 event wins over clear-all", 16'h0001);
    // R5 disable then tick drops lam
    drive(1, 5'd22, 4'd1, 16'h0001, 0);
    @(posedge clk); #1;
    chk("R6 lam masked bit0", {15'd0, lam}, 16'd1);
    drive(1, 5'd24, 4'd0, 0, 0);
    @(posedge clk); #1;
    chk("R5 en off", {15'd0, lam_en}, 16'd0);
    drive(0, 0, 0, 0, 1);
    @(posedge clk); #1;
    idle();
    chk("R5 lam off after tick", {15'd0, lam}, 16'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule